// File: doc/BRIEF.md
# Error-Tolerant Sync Word Detector

This block hunts for a fixed synchronisation word in a serial receive stream. Each accepted bit enters a window that holds the most recent received bits. The window is compared with a constant pattern, and the number of differing bits is counted. The word is taken as found when that count is no greater than a 3-bit programmable limit. The block then raises a found flag, keeps the measured error count, and emits a one-cycle event toward the interrupt logic.

After a match the block stops hunting. It packs the bits that follow into fixed-width symbols, most significant bit first, and stores them in a symbol buffer until the frame is complete. It then re-arms and hunts again. The host clears the flag with an explicit strobe or by reading status. High limits such as 5, 6 or 7 make false detection more likely, but the block still applies them exactly.

Top module: `sync_tolerant_detect`

## Requirements
- R1: A match is declared when the pattern window is full and the number of bits differing from the 48-bit pattern is less than or equal to `err_limit`. This holds for every limit from 0 to 7. A count one above the limit gives no match.
- R2: No match is declared until at least 48 accepted bits have entered the window since reset.
- R3: `found` becomes 1 on the clock edge that accepts the bit completing a match.
- R4: On a match, `err_count` takes the measured mismatch count. It holds that value, including across flag clears, until the next match or a reset.
- R5: After a match, the next 63 accepted bits groups of 6 bits are each packed first-received-bit-as-MSB. Symbol k is stored at `sym_buf[k*6 +: 6]`, for k from 0 to 62.
- R6: `sync_evt` is high for exactly one cycle, the same cycle in which a new match first shows on `found`.
- R7: While symbols are being captured, no match is searched for, even if the exact pattern arrives. Hunting resumes with the first bit accepted after the 63rd symbol is stored.
- R8: `clear_flag` or `status_rd` clears `found` on the next edge. If a match occurs in the same cycle, the match wins and `found` stays 1.
- R9: A synchronous active-high `rst` clears `found`, `err_count`, `sync_evt`, capture progress, the window fill and `sym_buf`.
- R10: A cycle with `bit_en` low changes neither the window nor the capture progress, whatever `bit_in` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` as a received bit this cycle |
| bit_in | input | 1 | Received serial data bit |
| err_limit | input | 3 | Largest accepted number of mismatched sync bits |
| clear_flag | input | 1 | Explicit clear strobe for `found` |
| status_rd | input | 1 | Host status read, also clears `found` |
| found | output | 1 | Sync-found flag |
| err_count | output | 3 | Mismatch count latched at the last match |
| sync_evt | output | 1 | One-cycle sync event toward the interrupt mask logic |
| sym_buf | output | 378 | Captured symbols, symbol k at bits k*6+5 down to k*6 |

## Verification
The bench builds the block with its default parameters: a 48-bit pattern, 6-bit symbols, 63 symbols per frame and the split population count. With these values, full-length frames, re-arming right after the last symbol, and the extreme limit of 7 can all be reached in a short run. The 48-bit fill rule can be exercised because a partly filled window already lies within 7 errors of the pattern. Bit gaps, clears that collide with matches, and a reset in the middle of capture are compared against a behavioural queue model on every clock.

// File: rtl/sdet_pkg.sv
package sdet_pkg;
   parameter int unsigned SDET_PAT_W   = 48;
   parameter int unsigned SDET_SYM_W   = 6;
   parameter int unsigned SDET_NUM_SYM = 63;
   parameter int unsigned SDET_LIM_W   = 3;
   parameter logic [SDET_PAT_W-1:0] SDET_PATTERN = 48'hA5F0_3C96_5AC3;

   function automatic int unsigned sdet_count_w(input int unsigned max_val);
      return $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/sdet_window.sv
module sdet_window
   import sdet_pkg::*;
#(
   parameter int unsigned PAT_W = SDET_PAT_W,
   parameter logic [PAT_W-1:0] PATTERN = SDET_PATTERN,
   parameter bit SPLIT_POP = 1'b1,
   localparam int unsigned DIST_W = sdet_count_w(PAT_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              bit_in,
   output logic [DIST_W-1:0] dist_next,
   output logic              full_next
);
   logic [PAT_W-1:0]  shreg;
   logic [PAT_W-1:0]  shifted;
   logic [PAT_W-1:0]  diff;
   logic [DIST_W-1:0] fill;

   assign shifted = {shreg[PAT_W-2:0], bit_in};
   assign diff    = shifted ^ PATTERN;

   generate
      if (SPLIT_POP) begin : g_split
         localparam int unsigned HALF = PAT_W / 2;
         logic [DIST_W-1:0] lo_cnt;
         logic [DIST_W-1:0] hi_cnt;
         always_comb begin
            lo_cnt = '0;
            hi_cnt = '0;
            for (int i = 0; i < HALF; i++) lo_cnt += DIST_W'(diff[i]);
            for (int i = HALF; i < PAT_W; i++) hi_cnt += DIST_W'(diff[i]);
         end
         assign dist_next = lo_cnt + hi_cnt;
      end else begin : g_flat
         logic [DIST_W-1:0] all_cnt;
         always_comb begin
            all_cnt = '0;
            for (int i = 0; i < PAT_W; i++) all_cnt += DIST_W'(diff[i]);
         end
         assign dist_next = all_cnt;
      end
   endgenerate

   assign full_next = (fill >= DIST_W'(PAT_W - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg <= '0;
         fill  <= '0;
      end else if (bit_en) begin
         shreg <= shifted;
         if (fill != DIST_W'(PAT_W)) fill <= fill + 1'b1;
      end
   end

   // R10
   window_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(shreg));

   // R2
   fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (fill < DIST_W'(PAT_W - 1)) |-> !full_next);
endmodule

// File: rtl/sdet_capture.sv
module sdet_capture
   import sdet_pkg::*;
#(
   parameter int unsigned SYM_W   = SDET_SYM_W,
   parameter int unsigned NUM_SYM = SDET_NUM_SYM,
   localparam int unsigned IDX_W  = $clog2(NUM_SYM),
   localparam int unsigned BIT_W  = $clog2(SYM_W),
   localparam int unsigned BUF_W  = SYM_W * NUM_SYM
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             bit_en,
   input  logic             bit_in,
   output logic             active,
   output logic [BUF_W-1:0] buf_data
);
   logic [BIT_W-1:0] bit_idx;
   logic [IDX_W-1:0] sym_idx;
   logic [SYM_W-1:0] acc;
   logic [SYM_W-1:0] sym_val;
   logic             take;
   logic             sym_done;
   logic             last_sym;

   assign take     = active && bit_en;
   assign sym_val  = {acc[SYM_W-2:0], bit_in};
   assign sym_done = take && (bit_idx == BIT_W'(SYM_W - 1));
   assign last_sym = (sym_idx == IDX_W'(NUM_SYM - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         active  <= 1'b0;
         bit_idx <= '0;
         sym_idx <= '0;
         acc     <= '0;
      end else if (start) begin
         active  <= 1'b1;
         bit_idx <= '0;
         sym_idx <= '0;
         acc     <= '0;
      end else if (take) begin
         acc <= sym_val;
         if (sym_done) begin
            bit_idx <= '0;
            if (last_sym) begin
               active  <= 1'b0;
               sym_idx <= '0;
            end else begin
               sym_idx <= sym_idx + 1'b1;
            end
         end else begin
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < NUM_SYM; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst)
               buf_data[g*SYM_W +: SYM_W] <= '0;
            else if (sym_done && (sym_idx == IDX_W'(g)))
               buf_data[g*SYM_W +: SYM_W] <= sym_val;
         end
      end
   endgenerate

   // R7
   rearm_chk: assert property (@(posedge clk) disable iff (rst)
      (sym_done && last_sym && !start) |=> !active);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!bit_en && !start) |=> ($stable(bit_idx) && $stable(sym_idx)));
endmodule

// File: rtl/sync_tolerant_detect.sv
module sync_tolerant_detect
   import sdet_pkg::*;
#(
   parameter int unsigned PAT_W   = SDET_PAT_W,
   parameter logic [PAT_W-1:0] PATTERN = SDET_PATTERN,
   parameter int unsigned SYM_W   = SDET_SYM_W,
   parameter int unsigned NUM_SYM = SDET_NUM_SYM,
   parameter int unsigned LIM_W   = SDET_LIM_W,
   parameter bit SPLIT_POP        = 1'b1,
   localparam int unsigned DIST_W = sdet_count_w(PAT_W),
   localparam int unsigned BUF_W  = SYM_W * NUM_SYM
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_en,
   input  logic             bit_in,
   input  logic [LIM_W-1:0] err_limit,
   input  logic             clear_flag,
   input  logic             status_rd,
   output logic             found,
   output logic [LIM_W-1:0] err_count,
   output logic             sync_evt,
   output logic [BUF_W-1:0] sym_buf
);
   generate
      if (PAT_W < (1 << LIM_W)) begin : g_bad_pat
         $error("pattern must be wider than the largest error limit");
      end
      if (SYM_W < 2) begin : g_bad_sym
         $error("symbols need at least two bits");
      end
      if (NUM_SYM < 2) begin : g_bad_num
         $error("frame needs at least two symbols");
      end
   endgenerate

   logic [DIST_W-1:0] dist_next;
   logic              full_next;
   logic              cap_active;
   logic              match;

   sdet_window #(
      .PAT_W    (PAT_W),
      .PATTERN  (PATTERN),
      .SPLIT_POP(SPLIT_POP)
   ) u_window (
      .clk      (clk),
      .rst      (rst),
      .bit_en   (bit_en),
      .bit_in   (bit_in),
      .dist_next(dist_next),
      .full_next(full_next)
   );

   assign match = bit_en && !cap_active && full_next &&
                  (dist_next <= DIST_W'(err_limit));

   sdet_capture #(
      .SYM_W  (SYM_W),
      .NUM_SYM(NUM_SYM)
   ) u_capture (
      .clk     (clk),
      .rst     (rst),
      .start   (match),
      .bit_en  (bit_en),
      .bit_in  (bit_in),
      .active  (cap_active),
      .buf_data(sym_buf)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         found     <= 1'b0;
         err_count <= '0;
         sync_evt  <= 1'b0;
      end else begin
         sync_evt <= match;
         if (match) begin
            found     <= 1'b1;
            err_count <= dist_next[LIM_W-1:0];
         end else if (clear_flag || status_rd) begin
            found <= 1'b0;
         end
      end
   end

   // R6
   evt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      sync_evt |=> !sync_evt);

   // R6
   evt_flag_chk: assert property (@(posedge clk) disable iff (rst)
      sync_evt |-> found);

   // R1
   count_lim_chk: assert property (@(posedge clk) disable iff (rst)
      sync_evt |-> (err_count <= $past(err_limit)));

   // R7
   no_hunt_chk: assert property (@(posedge clk) disable iff (rst)
      (cap_active && $past(cap_active)) |-> !sync_evt);

   // R8
   clear_chk: assert property (@(posedge clk) disable iff (rst)
      ((clear_flag || status_rd) && !match) |=> !found);
endmodule

// File: tb/sync_tolerant_detect_test.sv
`timescale 1ns/1ps
module sync_tolerant_detect_test;
   localparam int PAT_W   = 48;
   localparam int SYM_W   = 6;
   localparam int NUM_SYM = 63;
   localparam logic [PAT_W-1:0] PAT = 48'hA5F0_3C96_5AC3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ben = 1'b0;
   logic bin = 1'b0;
   logic [2:0] lim = 3'd0;
   logic clr = 1'b0;
   logic rd = 1'b0;
   logic found;
   logic [2:0] err_count;
   logic sync_evt;
   logic [SYM_W*NUM_SYM-1:0] sym_buf;

   int checks = 0;
   int failures = 0;
   bit started = 0;
   bit finished = 0;
   string phase = "R9";

   always #2 clk = ~clk;

   sync_tolerant_detect uut (
      .clk(clk), .rst(rst), .bit_en(ben), .bit_in(bin), .err_limit(lim),
      .clear_flag(clr), .status_rd(rd), .found(found), .err_count(err_count),
      .sync_evt(sync_evt), .sym_buf(sym_buf)
   );

   // behavioural reference model
   bit q[$];
   int m_found, m_cnt, m_evt, m_cap, m_nb, m_idx, m_acc;
   int m_buf[NUM_SYM];

   always @(posedge clk) begin
      started <= 1'b1;
      if (rst) begin
         q.delete();
         m_found = 0; m_cnt = 0; m_evt = 0; m_cap = 0; m_nb = 0; m_idx = 0; m_acc = 0;
         foreach (m_buf[i]) m_buf[i] = 0;
      end else begin
         m_evt = 0;
         if (clr || rd) m_found = 0;
         if (ben) begin
            q.push_back(bin);
            if (q.size() > PAT_W) void'(q.pop_front());
            if (m_cap == 0) begin
               if (q.size() == PAT_W) begin
                  int d;
                  d = 0;
                  for (int i = 0; i < PAT_W; i++) if (q[i] != PAT[PAT_W-1-i]) d++;
                  if (d <= int'(lim)) begin
                     m_found = 1; m_cnt = d; m_evt = 1; m_cap = 1;
                     m_nb = 0; m_idx = 0; m_acc = 0;
                  end
               end
            end else begin
               m_acc = ((m_acc << 1) | int'(bin)) & ((1 << SYM_W) - 1);
               m_nb++;
               if (m_nb == SYM_W) begin
                  m_buf[m_idx] = m_acc;
                  m_idx++; m_nb = 0; m_acc = 0;
                  if (m_idx == NUM_SYM) m_cap = 0;
               end
            end
         end
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s (phase %s) actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !finished) begin
         check("R3 found", int'(found), m_found);
         check("R4 err_count", int'(err_count), m_cnt);
         check("R6 sync_evt", int'(sync_evt), m_evt);
         for (int k = 0; k < NUM_SYM; k++)
            check("R5 sym_buf", int'(sym_buf[k*SYM_W +: SYM_W]), m_buf[k]);
      end
   end

   task automatic send_bit(bit b, bit c);
      @(negedge clk);
      if (($urandom % 7) == 0) begin
         ben = 1'b0; bin = ~b; clr = 1'b0;
         @(negedge clk);
      end
      ben = 1'b1; bin = b; clr = c;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ben = 1'b0; clr = 1'b0; rd = 1'b0; bin = $urandom;
      end
   endtask

   task automatic send_noise(int n);
      for (int i = 0; i < n; i++) send_bit(1'($urandom), 1'b0);
   endtask

   task automatic send_pat(int nerr, bit clr_last);
      logic [PAT_W-1:0] w;
      w = PAT;
      for (int e = 0; e < nerr; e++) w[e*5 + 1] = ~w[e*5 + 1];
      for (int i = PAT_W - 1; i >= 0; i--) send_bit(w[i], clr_last && (i == 0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R9 reset found", int'(found), 0);
      check("R9 reset count", int'(err_count), 0);

      phase = "R2";
      lim = 3'd7;
      for (int i = 40; i >= 0; i--) send_bit(PAT[i], 1'b0);
      idle(2);
      check("R2 no match before full window", int'(found), 0);

      phase = "R1";
      lim = 3'd2;
      send_noise(60);
      send_pat(3, 1'b0);
      idle(1);
      check("R1 over limit rejected", int'(found), 0);
      lim = 3'd3;
      send_pat(3, 1'b0);
      @(negedge clk);
      ben = 1'b0;
      check("R1 at limit accepted", int'(found), 1);
      check("R4 count three", int'(err_count), 3);
      check("R6 event with flag", int'(sync_evt), 1);

      phase = "R7";
      send_pat(0, 1'b0);
      idle(1);
      check("R7 no event during capture", int'(sync_evt), 0);
      phase = "R10";
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         ben = 1'b0; bin = ~bin;
      end
      phase = "R5";
      send_noise(SYM_W*NUM_SYM - PAT_W);
      idle(2);
      check("R5 first symbol", int'(sym_buf[SYM_W-1:0]), int'(PAT[PAT_W-1 -: SYM_W]));

      phase = "R8";
      @(negedge clk); rd = 1'b1;
      @(negedge clk); rd = 1'b0;
      check("R8 read clears flag", int'(found), 0);
      check("R4 count held", int'(err_count), 3);

      phase = "R1";
      lim = 3'd7;
      send_pat(7, 1'b0);
      idle(1);
      check("R1 limit seven", int'(err_count), 7);
      send_noise(SYM_W*NUM_SYM);
      phase = "R8";
      @(negedge clk); clr = 1'b1; ben = 1'b0;
      @(negedge clk); clr = 1'b0;
      check("R8 strobe clears flag", int'(found), 0);
      send_pat(0, 1'b1);
      idle(1);
      check("R8 match beats clear", int'(found), 1);
      check("R4 count zero", int'(err_count), 0);

      phase = "R9";
      send_noise(30);
      @(negedge clk); rst = 1'b1; ben = 1'b0;
      @(negedge clk); rst = 1'b0;
      check("R9 mid capture reset", int'(found), 0);
      check("R9 buffer cleared", int'(sym_buf[SYM_W-1:0]), 0);
      phase = "R1";
      lim = 3'd0;
      send_pat(0, 1'b0);
      idle(1);
      check("R1 exact match limit zero", int'(found), 1);
      send_noise(100);
      idle(3);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule